// File: doc/BRIEF.md
# Priority-Arbitrated Shared Memory Bank

This block is one bank of a multiprocessor shared-memory array. It holds a 256-word by 16-bit RAM that belongs to a single owner CPU, and up to sixteen CPU ports can reach it. Each port presents a strobe, a write enable, an 8-bit word offset, 16-bit write data and a 4-bit bank number. The bank number is the position of this bank in that CPU's own logical map.

An arbiter picks one requester per cycle. A CPU that places the bank higher in its map wins over one that places it lower, so senders of messages outrank ordinary local traffic. A losing CPU keeps its strobe high and receives no acknowledge until it wins. When any CPU other than the owner writes into the bank, a message interrupt to the owner is set. The interrupt stays set until the owner clears it.

A second, independent RAM port lets a host load code and inspect memory without going through the arbiter.

Top module: `msg_bank`

## Requirements
- R1: After synchronous reset, every `cpu_ack` bit is 0, `msg_irq` is 0 and all of `cpu_rdata` is 0.
- R2: A granted access is acknowledged by a one-cycle pulse on that port's `cpu_ack` bit, one clock after the cycle in which it was granted. For a read, the word at the offset is on that port's `cpu_rdata` slice during that same pulse.
- R3: A granted write (`cpu_we`=1) stores the port's write data at its offset, and a later read of that offset returns it.
- R4: Among eligible requesters, the one with the numerically largest 4-bit `cpu_prio` value is granted.
- R5: When the largest `cpu_prio` value is shared, the requester with the lowest port index is granted.
- R6: A requester that is not granted receives no acknowledge and is served in a later cycle; the bank never idles while an eligible request is pending.
- R7: A grant covers one access. A port acknowledged in a cycle is not eligible in that same cycle, even if its strobe is still high. A port that holds its strobe continuously is therefore served at most every second cycle.
- R8: A granted write from any port other than `OWNER` (default 0) sets `msg_irq` in the acknowledge cycle. Writes from the owner port and all reads leave it unchanged.
- R9: `msg_irq` stays at 1 until `msg_clr` is high at a clock edge with no new non-owner write. A set in the same cycle as a clear wins.
- R10: The host port reads and writes the same storage independently of arbitration, and `host_rdata` shows the addressed word one clock after `host_en`.
- R11: The `cpu_rdata` slice of every port whose `cpu_ack` bit is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 16 | Access strobe per CPU port |
| cpu_we | input | 16 | Write enable per CPU port |
| cpu_addr | input | 128 | Word offset, 8 bits per port, port i at [8i+7:8i] |
| cpu_wdata | input | 256 | Write data, 16 bits per port |
| cpu_prio | input | 64 | Bank number in the requester's map, 4 bits per port; higher wins |
| cpu_ack | output | 16 | One-cycle acknowledge per port |
| cpu_rdata | output | 256 | Read data per port, valid with its acknowledge |
| host_en | input | 1 | Host access enable |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host word offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the access |
| msg_clr | input | 1 | Owner clears the message interrupt |
| msg_irq | output | 1 | Message interrupt to the owner CPU |

## Verification
A wrong arbitration decision shows up one clock later as an acknowledge on the wrong port. Because every grant is one-hot and answered by a pulse, the error appears in the first contested cycle, not after a long drift. If the grant bookkeeping for an acknowledged port goes wrong, that port is acknowledged twice in a row or a waiting port goes unserved; either is visible within two cycles. A wrong interrupt flag is seen in the acknowledge cycle of the offending write, or in the cycle after a clear.

// File: rtl/msg_bank_pkg.sv
package msg_bank_pkg;
  localparam int DEF_PORTS  = 16;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_PRIO_W = 4;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msg_bank_arb.sv
module msg_bank_arb #(
  parameter int N  = msg_bank_pkg::DEF_PORTS,
  parameter int PW = msg_bank_pkg::DEF_PRIO_W,
  localparam int IW = msg_bank_pkg::idx_width(N)
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] prio,
  output logic [N-1:0]    grant,
  output logic [IW-1:0]   idx,
  output logic            any
);
  logic [PW-1:0] best;

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    best  = '0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || prio[i*PW +: PW] > best)) begin
        any  = 1'b1;
        best = prio[i*PW +: PW];
        idx  = IW'(i);
      end
    end
    grant[idx] = any;
  end
endmodule

// File: rtl/msg_bank_mux.sv
module msg_bank_mux #(
  parameter int N = msg_bank_pkg::DEF_PORTS,
  parameter int W = msg_bank_pkg::DEF_DATA_W,
  localparam int IW = msg_bank_pkg::idx_width(N)
) (
  input  logic [N*W-1:0] din,
  input  logic [IW-1:0]  sel,
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++)
      if (sel == IW'(i)) dout = din[i*W +: W];
  end
endmodule

// File: rtl/msg_bank_ram.sv
module msg_bank_ram #(
  parameter int AW = msg_bank_pkg::DEF_ADDR_W,
  parameter int DW = msg_bank_pkg::DEF_DATA_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) a_rdata <= mem[a_addr];
      if (b_en) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/msg_bank.sv
module msg_bank #(
  parameter int N     = msg_bank_pkg::DEF_PORTS,
  parameter int AW    = msg_bank_pkg::DEF_ADDR_W,
  parameter int DW    = msg_bank_pkg::DEF_DATA_W,
  parameter int PW    = msg_bank_pkg::DEF_PRIO_W,
  parameter int OWNER = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    cpu_req,
  input  logic [N-1:0]    cpu_we,
  input  logic [N*AW-1:0] cpu_addr,
  input  logic [N*DW-1:0] cpu_wdata,
  input  logic [N*PW-1:0] cpu_prio,
  output logic [N-1:0]    cpu_ack,
  output logic [N*DW-1:0] cpu_rdata,
  input  logic            host_en,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            msg_clr,
  output logic            msg_irq
);
  localparam int IW = msg_bank_pkg::idx_width(N);

  logic [N-1:0]  grant;
  logic [IW-1:0] gidx;
  logic          gany;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic          s_we;
  logic [DW-1:0] ram_rd;
  logic          msg_set;

  // a port acknowledged this cycle must re-arbitrate from the next one
  msg_bank_arb #(.N(N), .PW(PW)) u_arb (
    .elig(cpu_req & ~cpu_ack), .prio(cpu_prio),
    .grant(grant), .idx(gidx), .any(gany)
  );

  msg_bank_mux #(.N(N), .W(AW)) u_amux (.din(cpu_addr),  .sel(gidx), .dout(s_addr));
  msg_bank_mux #(.N(N), .W(DW)) u_dmux (.din(cpu_wdata), .sel(gidx), .dout(s_wdata));
  msg_bank_mux #(.N(N), .W(1))  u_wmux (.din(cpu_we),    .sel(gidx), .dout(s_we));

  msg_bank_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst(rst),
    .a_en(gany), .a_we(s_we), .a_addr(s_addr), .a_wdata(s_wdata), .a_rdata(ram_rd),
    .b_en(host_en), .b_we(host_we), .b_addr(host_addr), .b_wdata(host_wdata),
    .b_rdata(host_rdata)
  );

  assign msg_set = gany && s_we && (gidx != IW'(OWNER));

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ack <= '0;
      msg_irq <= 1'b0;
    end else begin
      cpu_ack <= grant;
      if (msg_set)      msg_irq <= 1'b1;
      else if (msg_clr) msg_irq <= 1'b0;
    end
  end

  // return path: only the acknowledged port sees the RAM word
  for (genvar i = 0; i < N; i++) begin : g_ret
    assign cpu_rdata[i*DW +: DW] = cpu_ack[i] ? ram_rd : '0;
  end
endmodule

// File: rtl/msg_bank_chk.sv
module msg_bank_chk #(
  parameter int N     = 16,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int PW    = 4,
  parameter int OWNER = 0
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    cpu_req,
  input logic [N-1:0]    cpu_we,
  input logic [N*PW-1:0] cpu_prio,
  input logic [N-1:0]    cpu_ack,
  input logic [N*DW-1:0] cpu_rdata,
  input logic            msg_clr,
  input logic            msg_irq
);
  logic            pv;
  logic [N-1:0]    p_req, p_ack, p_we;
  logic [N*PW-1:0] p_prio;
  logic            p_clr, p_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= 1'b0; p_req <= '0; p_ack <= '0; p_we <= '0;
      p_prio <= '0; p_clr <= 1'b0; p_irq <= 1'b0;
    end else begin
      pv <= 1'b1; p_req <= cpu_req; p_ack <= cpu_ack; p_we <= cpu_we;
      p_prio <= cpu_prio; p_clr <= msg_clr; p_irq <= msg_irq;
    end
  end

  logic [N-1:0] p_elig, owner_mask;
  assign p_elig = p_req & ~p_ack;
  always_comb begin
    owner_mask = '0;
    owner_mask[OWNER] = 1'b1;
  end

  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cpu_ack));

  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    pv |-> (cpu_ack & ~p_elig) == '0);

  p_one_access_r7: assert property (@(posedge clk) disable iff (rst)
    pv |-> (cpu_ack & p_ack) == '0);

  p_work_conserving_r6: assert property (@(posedge clk) disable iff (rst)
    (pv && p_elig != '0) |-> cpu_ack != '0);

  for (genvar i = 0; i < N; i++) begin : g_i
    p_quiet_rdata_r11: assert property (@(posedge clk) disable iff (rst)
      !cpu_ack[i] |-> cpu_rdata[i*DW +: DW] == '0);
    for (genvar j = 0; j < N; j++) begin : g_j
      if (j != i) begin : g_pair
        // R4 / R5: no eligible rival outranked the winner
        p_priority_r4: assert property (@(posedge clk) disable iff (rst)
          (pv && cpu_ack[i] && p_elig[j]) |->
            ((p_prio[j*PW +: PW] < p_prio[i*PW +: PW]) ||
             (p_prio[j*PW +: PW] == p_prio[i*PW +: PW] && j > i)));
      end
    end
  end

  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    (pv && msg_irq && !p_irq) |-> (cpu_ack & p_we & ~owner_mask) != '0);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (pv && p_irq && !p_clr) |-> msg_irq);
endmodule

bind msg_bank msg_bank_chk #(.N(N), .AW(AW), .DW(DW), .PW(PW), .OWNER(OWNER)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_prio(cpu_prio),
  .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .msg_clr(msg_clr), .msg_irq(msg_irq)
);

// File: tb/sim_msg_bank.sv
module sim_msg_bank;
  localparam int N = 16, AW = 8, DW = 16, PW = 4, OWNER = 0;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    cpu_req = '0, cpu_we = '0;
  logic [N*AW-1:0] cpu_addr = '0;
  logic [N*DW-1:0] cpu_wdata = '0;
  logic [N*PW-1:0] cpu_prio = '0;
  logic [N-1:0]    cpu_ack;
  logic [N*DW-1:0] cpu_rdata;
  logic            host_en = 1'b0, host_we = 1'b0;
  logic [AW-1:0]   host_addr = '0;
  logic [DW-1:0]   host_wdata = '0;
  logic [DW-1:0]   host_rdata;
  logic            msg_clr = 1'b0;
  logic            msg_irq;

  always #10 clk = ~clk;

  msg_bank #(.N(N), .AW(AW), .DW(DW), .PW(PW), .OWNER(OWNER)) u0 (.*);

  typedef struct {
    logic [N-1:0]  ack;
    logic          chk_rd;
    int            port;
    logic [DW-1:0] rd;
    logic          irq;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;

  logic [DW-1:0] mdl [256];
  logic          mdl_irq = 1'b0;
  int            b_cnt [N];
  logic          b_we  [N];
  logic [AW-1:0] b_addr[N];
  logic [DW-1:0] b_data[N];
  logic [PW-1:0] b_prio[N];
  logic          hold_clr = 1'b0;

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each result cycle against the scoreboard
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        item_t it;
        logic [N*DW-1:0] quiet;
        it = q.pop_front();
        check({it.tag, " ack"}, 256'(cpu_ack), 256'(it.ack));
        if (it.chk_rd)
          check({it.tag, " R2 rdata"}, 256'(cpu_rdata[it.port*DW +: DW]), 256'(it.rd));
        quiet = cpu_rdata;
        if (it.port >= 0) quiet[it.port*DW +: DW] = '0;
        check("R11 idle rdata", 256'(quiet != '0), 256'(0));
        check({it.tag, " R8/R9 irq"}, 256'(msg_irq), 256'(it.irq));
      end
    end
  end

  function automatic void clear_b();
    for (int i = 0; i < N; i++) begin
      b_cnt[i] = 0; b_we[i] = 1'b0; b_addr[i] = '0; b_data[i] = '0; b_prio[i] = '0;
    end
  endfunction

  // driver: presents all pending strobes, predicts the winner, pushes expectations
  task automatic burst(input string tag);
    logic [N-1:0] last = '0;
    bit more = 1'b1;
    while (more) begin
      int w = -1;
      item_t it;
      logic [N-1:0] pend = '0;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        pend[i] = (b_cnt[i] > 0);
        cpu_we[i] = b_we[i];
        cpu_addr[i*AW +: AW] = b_addr[i];
        cpu_wdata[i*DW +: DW] = b_data[i];
        cpu_prio[i*PW +: PW] = b_prio[i];
      end
      cpu_req = pend;
      msg_clr = hold_clr;
      for (int i = 0; i < N; i++)
        if (pend[i] && !last[i] && (w < 0 || b_prio[i] > b_prio[w])) w = i;
      it.ack = '0; it.chk_rd = 1'b0; it.port = w; it.rd = '0; it.tag = tag;
      if (w >= 0) begin
        it.ack[w] = 1'b1;
        if (b_we[w]) begin
          mdl[b_addr[w]] = b_data[w];
          if (w != OWNER) mdl_irq = 1'b1;
          else if (hold_clr) mdl_irq = 1'b0;
        end else begin
          it.chk_rd = 1'b1;
          it.rd = mdl[b_addr[w]];
          if (hold_clr) mdl_irq = 1'b0;
        end
        b_cnt[w]--; b_addr[w]++; b_data[w]++;
        last = '0; last[w] = 1'b1;
      end else begin
        if (hold_clr) mdl_irq = 1'b0;
        last = '0;
      end
      it.irq = mdl_irq;
      q.push_back(it);
      more = (pend != '0);
    end
    @(negedge clk);
    cpu_req = '0; msg_clr = 1'b0; hold_clr = 1'b0;
  endtask

  task automatic host_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
    if (!we) check("R10 host read", 256'(host_rdata), 256'(mdl[a]));
    else mdl[a] = d;
  endtask

  task automatic clear_irq();
    item_t it;
    @(negedge clk);
    msg_clr = 1'b1;
    mdl_irq = 1'b0;
    it.ack = '0; it.chk_rd = 1'b0; it.port = -1; it.rd = '0; it.irq = 1'b0;
    it.tag = "R9 clear";
    q.push_back(it);
    @(negedge clk);
    msg_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state (still in reset)
    check("R1 ack", 256'(cpu_ack), 256'(0));
    check("R1 irq", 256'(msg_irq), 256'(0));
    check("R1 rdata", 256'(cpu_rdata), 256'(0));
    @(negedge clk); rst = 1'b0;

    // R3 R7 R8: non-owner port 5 writes four words while holding its strobe
    clear_b();
    b_cnt[5] = 4; b_we[5] = 1'b1; b_addr[5] = 8'h10; b_data[5] = 16'hA100; b_prio[5] = 4'd2;
    burst("R7 R8 port5 writes");

    // R9: level holds until cleared
    check("R9 irq held", 256'(msg_irq), 256'(1));
    clear_irq();

    // R8: owner writes leave the interrupt low
    clear_b();
    b_cnt[0] = 2; b_we[0] = 1'b1; b_addr[0] = 8'h40; b_data[0] = 16'h0B00; b_prio[0] = 4'd0;
    burst("R8 owner writes");

    // R2 R3: read back the words written by port 5 and the owner
    clear_b();
    b_cnt[5] = 4; b_addr[5] = 8'h10; b_prio[5] = 4'd7;
    burst("R2 R3 readback");
    clear_b();
    b_cnt[0] = 2; b_addr[0] = 8'h40;
    burst("R3 owner readback");

    // R10: host fills a region, then CPUs read it under contention
    for (int k = 0; k < 8; k++) host_op(1'b1, 8'h80 + 8'(k), 16'hC000 + 16'(k * 3));
    clear_b();
    b_cnt[1] = 1; b_addr[1] = 8'h80; b_prio[1] = 4'd3;
    b_cnt[2] = 1; b_addr[2] = 8'h81; b_prio[2] = 4'd9;
    b_cnt[3] = 1; b_addr[3] = 8'h82; b_prio[3] = 4'd9;
    b_cnt[4] = 1; b_addr[4] = 8'h83; b_prio[4] = 4'd1;
    burst("R4 R5 R6 contention");

    // R5 R6 R7: two top-priority ports with repeated accesses and a low one
    clear_b();
    b_cnt[7] = 3; b_addr[7] = 8'h84; b_prio[7] = 4'd15;
    b_cnt[8] = 2; b_addr[8] = 8'h86; b_prio[8] = 4'd15;
    b_cnt[9] = 1; b_we[9] = 1'b1; b_addr[9] = 8'h20; b_data[9] = 16'h9999; b_prio[9] = 4'd0;
    burst("R5 R6 R7 interleave");
    clear_irq();

    // R9: set wins over a clear held in the same cycle
    clear_b();
    b_cnt[6] = 1; b_we[6] = 1'b1; b_addr[6] = 8'h30; b_data[6] = 16'h6060; b_prio[6] = 4'd4;
    hold_clr = 1'b1;
    burst("R9 set beats clear");

    // R10: host sees CPU-written data and CPUs see host data
    host_op(1'b0, 8'h10, '0);
    host_op(1'b0, 8'h20, '0);
    host_op(1'b0, 8'h30, '0);
    host_op(1'b0, 8'h85, '0);

    repeat (3) @(negedge clk);
    check("R6 queue drained", 256'(q.size()), 256'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule